// File: doc/BRIEF.md
# Two-Wire Block-Access Register Target

This block is a serial two-wire target that holds six eight-bit control registers. A bus controller reaches them through one fixed device address, using four transfer kinds: single-byte write, single-byte read, block write and block read. The register contents leave the block on a parallel bus that feeds the neighbouring output-gating and amplitude logic. Outside this block, `sda_oe` pulls the open-drain data line low, and the resolved line comes back on `sda_i`.

The system clock oversamples SCL and SDA. Each line passes through a synchronizer, and edge detection then yields clock rises and falls, start and stop conditions. The command byte sets the transfer mode and the starting register index. The index steps up by one after every data byte, in both directions.

Register byte `i` sits on `ctrl_regs[8*i+7 : 8*i]`. The enable bits are byte 0 bit 2 (reference output), byte 1 bit 2 and bit 0 (differential outputs 0 and 1), and byte 2 bits 7 and 6 (differential outputs 2 and 3). Byte 4 is the count register. In byte 5, bit 7 selects custom amplitude and bits 6:4 hold the amplitude code, from 300 mV (code 0) to 1000 mV (code 7) in 100 mV steps.

Top module: `smbt_target`

## Requirements
- R1: After reset, `ctrl_regs` reads, from byte 0 upward, 0x04, 0x05, 0xC0, 0x08, 0x06, 0xD8, and `sda_oe` is low.
- R2: An address byte whose upper seven bits equal 0x6B (0xD6 for a write, 0xD7 for a read) is acknowledged by driving SDA low in the ninth clock. Any other address is not acknowledged, and the block then neither drives SDA nor changes any register until the next start.
- R3: The command byte is always acknowledged. Its bit 7 set selects single-byte mode and bit 7 clear selects block mode. Bits 6:0 give the starting register index.
- R4: In single-byte mode, the first byte after the command is acknowledged and written to the indexed register.
- R5: In block mode, the first byte after the command is a byte count: it is acknowledged and stored nowhere. Every following byte is acknowledged and written to successive registers starting at the index. A stop after any complete byte keeps the bytes already written.
- R6: A byte read (address+write, single-byte command, repeated start, address+read) returns the indexed register.
- R7: A block read (address+write, block command, repeated start, address+read) first returns the current value of byte 4, then registers from the index upward while the controller acknowledges. After the controller's not-acknowledge the block releases SDA.
- R8: Indices 6 and above are acknowledged on write but leave every register unchanged, and read as 0x00.
- R9: Every byte, in either direction, travels most significant bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Resolved serial data line |
| sda_oe | output | 1 | High pulls the data line low |
| ctrl_regs | output | 48 | Six register bytes, byte 0 in the low bits |

## Verification
A wrong index or a write strobe sent to the wrong place shows on `ctrl_regs` within a few system clocks of the acknowledge clock edge. It also shows in the next read, as a byte taken from the wrong register. A link state machine that gets out of step with the bit count shows on the very next ninth clock, as an acknowledge missing where one is due or present where none is due, or as bits shifted within a returned byte. A wrong count source or a missed index step in block reads shows as a bad first or later byte of the same transfer.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_TX_LOAD
  } link_state_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_CNT, PH_DATA
  } rx_phase_t;
endpackage

// File: rtl/smbt_sync_edge.sv
module smbt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbt_regfile.sv
module smbt_regfile #(
  parameter int              NREG        = 6,
  parameter int              DW          = 8,
  parameter int              IDXW        = 7,
  parameter int              CNT_IDX     = 4,
  parameter logic [NREG*DW-1:0] RESET_IMAGE = 48'hD8_06_08_C0_05_04
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDXW-1:0]    wr_idx,
  input  logic [DW-1:0]      wr_data,
  input  logic [IDXW-1:0]    rd_idx,
  output logic [DW-1:0]      rd_data,
  output logic [DW-1:0]      cnt_data,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= RESET_IMAGE[i*DW +: DW];
      else if (wr_en && wr_idx == IDXW'(i))
        regs[i] <= wr_data;
    end
    assign flat[i*DW +: DW] = regs[i];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++)
      if (rd_idx == IDXW'(k)) rd_data = regs[k];
  end

  assign cnt_data = regs[CNT_IDX];

  assert_reset_image_R1: assert property (@(posedge clk)
    rst |=> (flat == RESET_IMAGE));

  assert_oob_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= IDXW'(NREG)) |=> $stable(flat));
endmodule

// File: rtl/smbt_link.sv
module smbt_link
  import smbt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6B,
  parameter int         IDXW     = 7,
  parameter int         DW       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [DW-1:0]   rd_data,
  input  logic [DW-1:0]   cnt_data,
  output logic [IDXW-1:0] ptr,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [DW-1:0]   wr_data,
  output logic            sda_drive
);
  localparam logic [3:0] BITS = 4'(DW);

  link_state_t   state;
  rx_phase_t     phase;
  logic [DW-1:0] shreg;
  logic [3:0]    bitcnt;
  logic          byte_mode, rd_mode, cnt_pending;
  logic [DW-1:0] tx_byte;

  assign tx_byte = cnt_pending ? cnt_data : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      phase       <= PH_ADDR;
      shreg       <= '0;
      bitcnt      <= '0;
      ptr         <= '0;
      byte_mode   <= 1'b0;
      rd_mode     <= 1'b0;
      cnt_pending <= 1'b0;
      sda_drive   <= 1'b0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state     <= ST_RX;
        phase     <= PH_ADDR;
        bitcnt    <= '0;
        sda_drive <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        sda_drive <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && bitcnt < BITS) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == BITS) begin
              bitcnt <= '0;
              if (phase == PH_ADDR && shreg[DW-1:1] != DEV_ADDR) begin
                state <= ST_IDLE;
              end else begin
                state     <= ST_RX_ACK;
                sda_drive <= 1'b1;
                case (phase)
                  PH_ADDR: begin
                    rd_mode     <= shreg[0];
                    cnt_pending <= shreg[0] & ~byte_mode;
                    phase       <= PH_CMD;
                  end
                  PH_CMD: begin
                    ptr       <= shreg[IDXW-1:0];
                    byte_mode <= shreg[DW-1];
                    phase     <= shreg[DW-1] ? PH_DATA : PH_CNT;
                  end
                  PH_CNT: phase <= PH_DATA;
                  default: begin
                    wr_en   <= 1'b1;
                    wr_idx  <= ptr;
                    wr_data <= shreg;
                    ptr     <= ptr + 1'b1;
                  end
                endcase
              end
            end
          end
          ST_RX_ACK, ST_TX_LOAD: begin
            if (scl_fall) begin
              if (state == ST_RX_ACK && !rd_mode) begin
                sda_drive <= 1'b0;
                state     <= ST_RX;
              end else begin
                state     <= ST_TX;
                bitcnt    <= 4'd1;
                shreg     <= tx_byte;
                sda_drive <= ~tx_byte[DW-1];
                if (cnt_pending) cnt_pending <= 1'b0;
                else             ptr <= ptr + 1'b1;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == BITS) begin
                sda_drive <= 1'b0;
                state     <= ST_TX_ACK;
              end else begin
                sda_drive <= ~shreg[DW-2];
                shreg     <= {shreg[DW-2:0], 1'b0};
                bitcnt    <= bitcnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) state <= sda_s ? ST_IDLE : ST_TX_LOAD;
          end
          default: ;
        endcase
      end
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_drive);

  assert_write_with_ack_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (sda_drive && state == ST_RX_ACK));

  assert_ctrl_ack_released_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK) |-> !sda_drive);

  assert_bitcnt_range_R9: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= BITS);
endmodule

// File: rtl/smbt_target.sv
module smbt_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h6B,
  parameter int         NREG        = 6,
  parameter int         DW          = 8,
  parameter int         IDXW        = 7,
  parameter int         CNT_IDX     = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [NREG*DW-1:0] RESET_IMAGE = 48'hD8_06_08_C0_05_04
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREG*DW-1:0] ctrl_regs
);
  logic            sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [IDXW-1:0] ptr, wr_idx;
  logic            wr_en;
  logic [DW-1:0]   wr_data, rd_data, cnt_data;

  smbt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbt_link #(.DEV_ADDR(DEV_ADDR), .IDXW(IDXW), .DW(DW)) u_link (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .cnt_data(cnt_data), .ptr(ptr), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .sda_drive(sda_oe)
  );

  smbt_regfile #(
    .NREG(NREG), .DW(DW), .IDXW(IDXW), .CNT_IDX(CNT_IDX),
    .RESET_IMAGE(RESET_IMAGE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_data),
    .cnt_data(cnt_data), .flat(ctrl_regs)
  );
endmodule

// File: tb/sim_smbt_target.sv
module sim_smbt_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_scl = 1'b1;
  logic        m_sda_low = 1'b0;
  logic        sda_oe;
  logic [47:0] ctrl_regs;
  wire         sda_bus = ~(m_sda_low | sda_oe);

  int tests = 0, fails = 0, mism = 0;
  bit cmp_on = 0, done = 0;
  logic [7:0] mdl [6];

  always #(CLK_PERIOD/2) clk = ~clk;

  smbt_target u0 (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .ctrl_regs(ctrl_regs)
  );

  function automatic logic [47:0] mdl_img();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  function automatic logic [7:0] mdl_rd(int idx);
    return (idx < 6) ? mdl[idx] : 8'h00;
  endfunction

  always @(negedge clk)
    if (cmp_on && !rst && ctrl_regs != mdl_img()) mism++;

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(string tag);
    mism = 0;
    cmp_on = 1;
    wclk(30);
    cmp_on = 0;
    chk(mism == 0, tag, ctrl_regs, mdl_img());
  endtask

  task automatic bus_start();
    m_sda_low = 0; wclk(HALF/2);
    m_scl = 1;     wclk(HALF/2);
    m_sda_low = 1; wclk(HALF/2);
    m_scl = 0;     wclk(HALF/2);
  endtask

  task automatic bus_stop();
    m_sda_low = 1; wclk(HALF/2);
    m_scl = 1;     wclk(HALF/2);
    m_sda_low = 0; wclk(HALF);
  endtask

  task automatic bit_cycle(bit drive_low, output bit sampled);
    m_sda_low = drive_low; wclk(HALF/2);
    m_scl = 1;             wclk(HALF/2);
    sampled = sda_bus;     wclk(HALF/2);
    m_scl = 0;             wclk(HALF/2);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bit_cycle(~b[i], s);
    bit_cycle(1'b0, s);
    acked = ~s;
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b0, s);
      b[i] = s;
    end
    bit_cycle(give_ack, s);
    m_sda_low = 0;
  endtask

  task automatic send_ack(logic [7:0] b, string tag);
    bit a;
    send_byte(b, a);
    chk(a, tag, {47'd0, a}, 48'd1);
  endtask

  task automatic set_cmd(logic [7:0] cmd, string tag);
    bus_start();
    send_ack(8'hD6, tag);
    send_ack(cmd, tag);
  endtask

  // R4: single-byte write
  task automatic byte_write(int idx, logic [7:0] d, string tag);
    set_cmd(8'h80 | 8'(idx), tag);
    send_ack(d, tag);
    bus_stop();
    if (idx < 6) mdl[idx] = d;
  endtask

  // R5: block write with count byte; count differs from data length
  task automatic block_write(int idx, logic [7:0] cnt, logic [7:0] d [$], string tag);
    set_cmd(8'(idx), tag);
    send_ack(cnt, tag);
    foreach (d[k]) begin
      send_ack(d[k], tag);
      if (idx + k < 6) mdl[idx + k] = d[k];
    end
    bus_stop();
  endtask

  // R6: single-byte read
  task automatic byte_read(int idx, string tag);
    logic [7:0] b;
    set_cmd(8'h80 | 8'(idx), tag);
    bus_start();
    send_ack(8'hD7, tag);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == mdl_rd(idx), tag, {40'd0, b}, {40'd0, mdl_rd(idx)});
    chk(!sda_oe, tag, {47'd0, sda_oe}, 48'd0);
  endtask

  // R7: block read, count from byte 4 first, then n data bytes
  task automatic block_read(int idx, int n, string tag);
    logic [7:0] b;
    set_cmd(8'(idx), tag);
    bus_start();
    send_ack(8'hD7, tag);
    recv_byte(1'b1, b);
    chk(b == mdl[4], {tag, " count"}, {40'd0, b}, {40'd0, mdl[4]});
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == mdl_rd(idx + k), tag, {40'd0, b}, {40'd0, mdl_rd(idx + k)});
    end
    bus_stop();
    chk(!sda_oe, {tag, " release"}, {47'd0, sda_oe}, 48'd0);
  endtask

  initial begin
    bit a;
    mdl[0] = 8'h04; mdl[1] = 8'h05; mdl[2] = 8'hC0;
    mdl[3] = 8'h08; mdl[4] = 8'h06; mdl[5] = 8'hD8;
    wclk(5);
    rst = 0;
    wclk(1);
    chk(ctrl_regs == mdl_img(), "R1 reset image", ctrl_regs, mdl_img());
    chk(!sda_oe, "R1 reset sda_oe", {47'd0, sda_oe}, 48'd0);
    wclk(10);

    block_read(0, 6, "R7 R1 reset readback");
    byte_write(1, 8'h1D, "R4 R3 R9 byte write");
    chk_regs("R4 regs after byte write");
    byte_read(1, "R6 R9 byte read");
    block_write(2, 8'h03, '{8'h11, 8'h22, 8'h33}, "R5 block write");
    chk_regs("R5 regs after block write");
    block_read(0, 4, "R7 block read");
    block_write(0, 8'h05, '{8'hAA, 8'hB1}, "R5 early stop");
    chk_regs("R5 regs after early stop");

    // R2: foreign address is refused and later bytes are ignored
    bus_start();
    send_byte(8'hA0, a);
    chk(!a, "R2 foreign address nack", {47'd0, a}, 48'd0);
    send_byte(8'h80, a);
    chk(!a, "R2 ignored byte nack", {47'd0, a}, 48'd0);
    send_byte(8'h55, a);
    bus_stop();
    chk_regs("R2 regs untouched");

    byte_write(6, 8'hFF, "R8 out of range write");
    chk_regs("R8 regs after oob write");
    block_write(4, 8'h03, '{8'h0E, 8'h77, 8'h99}, "R8 R5 write across end");
    chk_regs("R8 regs after wrap write");
    block_read(5, 3, "R8 R7 read across end");
    byte_read(127, "R8 byte read high index");
    byte_read(5, "R6 byte read last");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule